// File: doc/BRIEF.md
# Next Pending Interrupt Encoder

This block reduces the pending state of a three-bank interrupt controller to one packed identifier: the interrupt that service software should handle next. It looks at three 32-bit pending words. The first is a base word that holds eight direct lines, two bank summary flags and eleven shortcut flags. The other two are the full pending words of wide banks 1 and 2. From these it picks a single winner by a fixed priority.

The chosen interrupt is returned as a 7-bit identifier. The upper two bits carry the bank number and the lower five bits carry the line within that bank. A shortcut flag is not reported as its own position in the base word. It is translated through a fixed table to the real bank and line that it stands for.

Software reads the result through a single read port, and the value is returned one cycle after the read strobe. There is no acknowledge. Each read reflects the pending words present in the cycle of the strobe, so once a source clears, the next read moves on to the next interrupt.

Top module: `next_irq_encoder`

## Requirements
- R1: A read result carries the identifier in bits 6:0, formed as (bank << 5) | line. Bit 31 is a valid flag, and bits 30:7 are zero.
- R2: Bits 21 to 31 of the base pending word have no effect on the result.
- R3: The groups are taken in a fixed priority order, from highest to lowest:
  - base lines (bits 0-7);
  - bank 1 shortcut flags (bits 10-14);
  - bank 2 shortcut flags (bits 15-20);
  - the bank 1 summary flag (bit 8);
  - the bank 2 summary flag (bit 9).
- R4: Within a group, the lowest-numbered set bit wins.
- R5: Shortcut flags translate through a fixed table, in order of base bit:
  - bits 10-14 map to bank 1 lines 7, 9, 10, 18 and 19;
  - bits 15-20 map to bank 2 lines 21, 22, 23, 24, 25 and 30.
- R6: A set summary flag reports the lowest set bit of that bank's pending word as the line. If the flag is set but the bank word is zero, the flag is passed over and priority moves on to the next group.
- R7: When nothing qualifies, the result is 0x0000007F: the identifier is all ones and the valid flag is clear.
- R8: Read timing and reset behave as follows:
  - rd_data shows the result one cycle after a cycle with rd_en high;
  - rd_data is zero one cycle after a cycle with rd_en low;
  - rd_data is zero during reset.
- R9: The result is recomputed on every read with no acknowledge. Bank pending words whose summary flag is clear raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_pend | input | 32 | Base pending word: direct lines, summaries, shortcuts |
| bank1_pend | input | 32 | Bank 1 pending word |
| bank2_pend | input | 32 | Bank 2 pending word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read result: valid flag in bit 31, identifier in bits 6:0 |

## Verification
Several decoders can claim an interrupt in the same cycle. A base line can collide with a shortcut flag, a shortcut can collide with a summary, and both summaries can be set together. These cases are provoked by vectors that raise several groups at once, and each is judged by whether the identifier belongs to the group higher in the order. A second collision comes from a source that clears between two back-to-back reads. For that case the bench checks that the second read reports the next interrupt in line rather than the stale one.

// File: rtl/nxt_irq_pkg.sv
// Package: shared types and the shortcut translation table for the
// next pending interrupt encoder.
// Assumes the bank line field is 5 bits (32 lines per bank).
package nxt_irq_pkg;

    localparam int unsigned LINE_BITS = 5;
    localparam int unsigned BANK_BITS = 2;
    localparam int unsigned ID_BITS   = BANK_BITS + LINE_BITS;

    // One candidate from a decoder group
    typedef struct packed {
        logic                 hit;
        logic [BANK_BITS-1:0] bank;
        logic [LINE_BITS-1:0] line;
    } irq_pick_t;

    // Map a shortcut flag index within its group to the real bank line
    function automatic logic [LINE_BITS-1:0] shortcut_line(
        input logic       second_group,
        input logic [2:0] k
    );
        logic [LINE_BITS-1:0] r;
        r = '0;
        if (!second_group) begin
            case (k)
                3'd0: r = 5'd7;
                3'd1: r = 5'd9;
                3'd2: r = 5'd10;
                3'd3: r = 5'd18;
                3'd4: r = 5'd19;
                default: r = '0;
            endcase
        end else begin
            case (k)
                3'd0: r = 5'd21;
                3'd1: r = 5'd22;
                3'd2: r = 5'd23;
                3'd3: r = 5'd24;
                3'd4: r = 5'd25;
                3'd5: r = 5'd30;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/lowest_set_idx.sv
// Module: finds the index of the lowest set bit of a vector.
// Assumes W >= 2. Output idx is zero when nothing is set.
module lowest_set_idx #(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/shortcut_decode.sv
// Module: turns one group of shortcut flags into a bank/line candidate.
// Assumes SC_N <= 8 and that the package table covers every flag.
module shortcut_decode
    import nxt_irq_pkg::*;
#(
    parameter int unsigned SC_N   = 5,
    parameter bit          SECOND = 1'b0,
    localparam int unsigned KW    = $clog2(SC_N)
) (
    input  logic [SC_N-1:0] sc_bits,
    output irq_pick_t       pick
);

    logic          any_set;
    logic [KW-1:0] k_idx;

    lowest_set_idx #(.W(SC_N)) u_low (
        .vec   (sc_bits),
        .found (any_set),
        .idx   (k_idx)
    );

    // Translate the winning flag to its real bank and line
    always_comb begin
        pick.hit  = any_set;
        pick.bank = SECOND ? 2'd2 : 2'd1;
        pick.line = shortcut_line(SECOND, 3'(k_idx));
    end

endmodule

// File: rtl/bank_summary_decode.sv
// Module: resolves a bank summary flag to the lowest pending line of that bank.
// Assumes a summary set with an empty bank word yields no candidate.
module bank_summary_decode
    import nxt_irq_pkg::*;
#(
    parameter int unsigned LINES   = 32,
    parameter int unsigned BANK_NO = 1
) (
    input  logic             summary,
    input  logic [LINES-1:0] bank_word,
    output irq_pick_t        pick
);

    logic                       any_line;
    logic [$clog2(LINES)-1:0]   line_idx;

    lowest_set_idx #(.W(LINES)) u_low (
        .vec   (bank_word),
        .found (any_line),
        .idx   (line_idx)
    );

    // Candidate exists only when the flag and a real line agree
    always_comb begin
        pick.hit  = summary && any_line;
        pick.bank = BANK_BITS'(BANK_NO);
        pick.line = LINE_BITS'(line_idx);
    end

endmodule

// File: rtl/priority_merge.sv
// Module: chooses the first hitting candidate; index 0 has top priority.
// Assumes N >= 1. With no hit, the identifier is all ones.
module priority_merge
    import nxt_irq_pkg::*;
#(
    parameter int unsigned N = 5
) (
    input  irq_pick_t          picks [N],
    output logic               any_hit,
    output logic [ID_BITS-1:0] id
);

    // Walk from lowest priority upward so the highest hit wins
    always_comb begin
        any_hit = 1'b0;
        id      = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (picks[i].hit) begin
                any_hit = 1'b1;
                id      = {picks[i].bank, picks[i].line};
            end
        end
    end

endmodule

// File: rtl/next_irq_encoder.sv
// Module: top of the next pending interrupt encoder. Combines base lines,
// shortcut groups and bank summaries by fixed priority and returns the
// winner through a one-cycle read port.
// Assumes pending words are stable in the cycle rd_en is high.
module next_irq_encoder
    import nxt_irq_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned BASE_LINES = 8,
    parameter int unsigned SUM1_POS   = 8,
    parameter int unsigned SUM2_POS   = 9,
    parameter int unsigned SC1_LSB    = 10,
    parameter int unsigned SC1_N      = 5,
    parameter int unsigned SC2_N      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] base_pend,
    input  logic [WORD_W-1:0] bank1_pend,
    input  logic [WORD_W-1:0] bank2_pend,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data
);

    localparam int unsigned SC2_LSB = SC1_LSB + SC1_N;
    localparam int unsigned N_GRP   = 5;
    localparam int unsigned PAD_W   = WORD_W - 1 - ID_BITS;
    localparam int unsigned BIW     = $clog2(BASE_LINES);

    irq_pick_t          picks [N_GRP];
    logic               base_any;
    logic [BIW-1:0]     base_idx;
    logic               any_hit;
    logic [ID_BITS-1:0] next_id;

    lowest_set_idx #(.W(BASE_LINES)) u_base (
        .vec   (base_pend[BASE_LINES-1:0]),
        .found (base_any),
        .idx   (base_idx)
    );

    // Base line candidate, always bank 0
    always_comb begin
        picks[0].hit  = base_any;
        picks[0].bank = 2'd0;
        picks[0].line = LINE_BITS'(base_idx);
    end

    shortcut_decode #(.SC_N(SC1_N), .SECOND(1'b0)) u_sc1 (
        .sc_bits (base_pend[SC1_LSB +: SC1_N]),
        .pick    (picks[1])
    );

    shortcut_decode #(.SC_N(SC2_N), .SECOND(1'b1)) u_sc2 (
        .sc_bits (base_pend[SC2_LSB +: SC2_N]),
        .pick    (picks[2])
    );

    bank_summary_decode #(.LINES(WORD_W), .BANK_NO(1)) u_sum1 (
        .summary   (base_pend[SUM1_POS]),
        .bank_word (bank1_pend),
        .pick      (picks[3])
    );

    bank_summary_decode #(.LINES(WORD_W), .BANK_NO(2)) u_sum2 (
        .summary   (base_pend[SUM2_POS]),
        .bank_word (bank2_pend),
        .pick      (picks[4])
    );

    priority_merge #(.N(N_GRP)) u_merge (
        .picks   (picks),
        .any_hit (any_hit),
        .id      (next_id)
    );

    // Read register: result on strobe, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= {any_hit, {PAD_W{1'b0}}, next_id};
        else
            rd_data <= '0;
    end

endmodule

// File: rtl/next_irq_encoder_chk.sv
// Module: property checker for next_irq_encoder, bound to every instance.
// Assumes the default field positions of the top module.
module next_irq_encoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] base_pend,
    input logic [31:0] bank1_pend,
    input logic [31:0] bank2_pend,
    input logic        rd_en,
    input logic [31:0] rd_data
);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == 32'h0);

    // R1
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] |-> (rd_data[30:7] == 24'h0 && rd_data[6:5] != 2'b11));

    // R7
    empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && base_pend[20:0] == 21'h0) |=> rd_data == 32'h0000_007F);

    // R3
    base_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && base_pend[7:0] != 8'h0) |=> (rd_data[31] && rd_data[6:5] == 2'b00));

    // R3
    sc1_over_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && base_pend[7:0] == 8'h0 && base_pend[14:10] != 5'h0)
        |=> (rd_data[31] && rd_data[6:5] == 2'b01));

    // R9
    summary_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && base_pend[20:8] == 13'h0 && base_pend[7:0] == 8'h0
         && (bank1_pend != 32'h0 || bank2_pend != 32'h0)) |=> !rd_data[31]);

endmodule

bind next_irq_encoder next_irq_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_pend  (base_pend),
    .bank1_pend (bank1_pend),
    .bank2_pend (bank2_pend),
    .rd_en      (rd_en),
    .rd_data    (rd_data)
);

// File: tb/sim_next_irq_encoder.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset, idle and update tests.
module sim_next_irq_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_pend = '0;
    logic [31:0] bank1_pend = '0;
    logic [31:0] bank2_pend = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    next_irq_encoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_pend  (base_pend),
        .bank1_pend (bank1_pend),
        .bank2_pend (bank2_pend),
        .rd_en      (rd_en),
        .rd_data    (rd_data)
    );

    // {base, bank1, bank2, expected}
    localparam int NV = 18;
    localparam logic [127:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0, 32'h0, 32'h0000_007F},          // R7 empty
        {32'h0000_00A0, 32'h0, 32'h0, 32'h8000_0005},          // R4 base lowest
        {32'h0000_0401, 32'h0, 32'h0, 32'h8000_0000},          // R3 base over shortcut
        {32'h0000_0C00, 32'h0, 32'h0, 32'h8000_0027},          // R5 bit10 -> 1:7
        {32'h0000_4000, 32'h0, 32'h0, 32'h8000_0033},          // R5 bit14 -> 1:19
        {32'h0000_1000, 32'h0, 32'h0, 32'h8000_002A},          // R5 bit12 -> 1:10
        {32'h0000_2000, 32'h0, 32'h0, 32'h8000_0032},          // R5 bit13 -> 1:18
        {32'h0010_8000, 32'h0, 32'h0, 32'h8000_0055},          // R4 bit15 -> 2:21
        {32'h0001_0000, 32'h0, 32'h0, 32'h8000_0056},          // R5 bit16 -> 2:22
        {32'h0010_0000, 32'h0, 32'h0, 32'h8000_005E},          // R5 bit20 -> 2:30
        {32'h0004_0100, 32'h10, 32'h0, 32'h8000_0058},         // R3 shortcut over summary
        {32'h0000_0300, 32'h300, 32'h1, 32'h8000_0028},        // R6 summary1 lowest
        {32'h0000_0200, 32'hFFFF, 32'h8000_0000, 32'h8000_005F}, // R6 summary2 line31
        {32'hFFE0_0000, 32'h0, 32'h0, 32'h0000_007F},          // R2 high bits ignored
        {32'hFFE0_0008, 32'h0, 32'h0, 32'h8000_0003},          // R2 high bits with base
        {32'h0000_0300, 32'h0, 32'h4, 32'h8000_0042},          // R6 empty bank falls through
        {32'h0000_0100, 32'h0, 32'h0, 32'h0000_007F},          // R6 empty bank, none left
        {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_007F} // R9 no summary
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one read and return the sampled result
    task automatic do_read(input logic [31:0] b, input logic [31:0] p1,
                           input logic [31:0] p2, output logic [31:0] res);
        @(negedge clk);
        base_pend = b; bank1_pend = p1; bank2_pend = p2; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        res = rd_data;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        check("R8 reset", rd_data, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], r);
            check($sformatf("R1 R3 R4 R5 R6 vector %0d", i), r, VEC[i][31:0]);
        end

        // R8: no strobe gives zero even with pending work
        @(negedge clk);
        base_pend = 32'h1; rd_en = 1'b0;
        @(negedge clk);
        check("R8 idle read", rd_data, 32'h0);

        // R9: back-to-back reads, source clears between them
        @(negedge clk);
        base_pend = 32'h0000_0402; rd_en = 1'b1;
        @(negedge clk);
        check("R9 first read", rd_data, 32'h8000_0001);
        base_pend = 32'h0000_0400;
        @(negedge clk);
        check("R9 after clear", rd_data, 32'h8000_0027);
        rd_en = 1'b0;

        // R8: reset mid-run clears the read register
        @(negedge clk);
        base_pend = 32'h4; rd_en = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset mid-run", rd_data, 32'h0);
        rst_n = 1'b1; rd_en = 1'b0;
        do_read(32'h4, 32'h0, 32'h0, r);
        check("R8 after reset", r, 32'h8000_0002);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule